// File: doc/BRIEF.md
# Partial Flag Threshold and Offset Loader

This block sits beside a synchronous FIFO's storage and pointer logic and produces the two partial status flags, almost-empty and almost-full, both active low. It compares the FIFO's current word count with two offsets. The lower offset, X, sets the almost-empty threshold. The upper offset, Y, sets the almost-full distance from the full depth. It also produces a hold-off that keeps the FIFO's input-ready output low until the offsets are in place.

The offsets are set up at every full reset. The mode pins are sampled on each clock edge while the full reset is held. Their value at the last such edge picks one of three sources:
- a fixed preset of 8, 16 or 64, applied to both offsets;
- a parallel load, in which two writes on the write port carry X and then Y;
- a serial load, in which a serial data pin is shifted in one bit per enabled clock, Y most significant bit first and X least significant bit last.

A partial reset leaves the programmed offsets untouched and only holds input-ready low.

The control state machine has five states:
- `ST_RESET`: held while the full reset is asserted.
- `ST_PAR_X`: waiting for the first bus write.
- `ST_PAR_Y`: waiting for the second bus write.
- `ST_SERIAL`: shifting offset bits.
- `ST_RUN`: normal operation.

Its transitions are:
- `ST_RESET` goes to `ST_RUN` for a preset, to `ST_SERIAL` for a serial load, and to `ST_PAR_X` otherwise, on the first edge after the full reset is released.
- `ST_PAR_X` goes to `ST_PAR_Y` on a write.
- `ST_PAR_Y` goes to `ST_RUN` on a write.
- `ST_SERIAL` goes to `ST_RUN` on the edge that captures the last bit.
- `ST_RUN` stays in `ST_RUN` until the next full reset.

Top module: `pflag_offset_unit`

## Requirements
- R1: With `preset_sel_i`=1 at the last clock edge of a full reset, `fsel_i` values 2'b01, 2'b10 and 2'b11 set both X and Y to 8, 16 and 64. `in_ready_o` is high after the first edge following the release.
- R2: With `preset_sel_i`=0 and `fsel_i`=2'b10 at the last reset edge, the serial load mode is selected.
- R3: Every other pin combination selects the parallel load. The first `wr_en_i` write loads X from `wr_data_i` and the second loads Y.
- R4: `in_ready_o` is low while the full reset is held and during a load. It rises at the edge that captures the final offset value: the second bus write, or the last serial bit.
- R5: In serial mode, a bit is taken only on an edge where `ser_en_n_i` is 0, and edges with it at 1 change nothing. After 2·log2(DEPTH) bits, the first bit sent is Y's MSB and the last bit sent is X's LSB.
- R6: Once loading is done, further serial bits and bus writes leave X and Y unchanged.
- R7: `almost_empty_n_o` is 0 when `word_cnt_i` ≤ X and 1 when `word_cnt_i` ≥ X+1.
- R8: `almost_full_n_o` is 0 when `word_cnt_i` ≥ DEPTH−Y and 1 when `word_cnt_i` ≤ DEPTH−(Y+1).
- R9: While `prst_n` is 0, `in_ready_o` is 0 and X and Y keep their values. `in_ready_o` returns to 1 when `prst_n` is released.
- R10: A new full reset discards the previous offsets and applies the newly selected configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Full reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, active low; offsets kept |
| preset_sel_i | input | 1 | Mode pin: 1 selects the preset family |
| fsel_i | input | 2 | Preset/serial selector pins, sampled during reset |
| ser_bit_i | input | 1 | Serial offset data |
| ser_en_n_i | input | 1 | Serial shift enable, active low |
| wr_en_i | input | 1 | Write-port enable |
| wr_data_i | input | log2(DEPTH) | Offset field of the write data bus |
| word_cnt_i | input | log2(DEPTH)+1 | Current FIFO word count |
| almost_empty_n_o | output | 1 | Almost-empty flag, active low |
| almost_full_n_o | output | 1 | Almost-full flag, active low |
| x_off_o | output | log2(DEPTH) | Current X offset |
| y_off_o | output | log2(DEPTH) | Current Y offset |
| in_ready_o | output | 1 | Input-ready hold-off, high when writes may proceed |

## Verification
The bench builds the block with DEPTH=128. This gives 7-bit offsets and a 14-bit serial stream, and it is the smallest depth that still holds the 64 preset. At this size every word count from 0 to 128 can be swept for each offset pair, so both flag thresholds are crossed at X, X+1, DEPTH−Y and DEPTH−(Y+1). The extremes X=Y=0 and X=Y=127 are swept as well. All three load sources run through the same depth, including disabled serial cycles and stray bits after completion.

// File: rtl/pfo_pkg.sv
package pfo_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_PAR_X,
        ST_PAR_Y,
        ST_SERIAL,
        ST_RUN
    } pfo_state_e;

    typedef enum logic [1:0] {
        LM_PRESET,
        LM_PARALLEL,
        LM_SERIAL
    } load_mode_e;

    // Decode the reset-time mode pins into a load source.
    function automatic load_mode_e decode_mode(input logic preset_sel,
                                               input logic [1:0] fsel);
        if (preset_sel && (fsel != 2'b00))
            return LM_PRESET;
        else if (!preset_sel && (fsel == 2'b10))
            return LM_SERIAL;
        else
            return LM_PARALLEL;
    endfunction

    // Preset offset value for a selector code; 0 when not a preset code.
    function automatic int unsigned preset_offset(input logic [1:0] fsel);
        unique case (fsel)
            2'b01:   return 8;
            2'b10:   return 16;
            2'b11:   return 64;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pfo_bit_counter.sv
module pfo_bit_counter #(
    parameter int NBITS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic last_o
);
    localparam int CNTW = $clog2(NBITS + 1);

    logic [CNTW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step_i && (cnt_q != CNTW'(NBITS)))
            cnt_q <= cnt_q + 1'b1;
    end

    // The step that brings the count to NBITS captures the final bit.
    assign last_o = step_i && (cnt_q == CNTW'(NBITS - 1));

endmodule

// File: rtl/pfo_offset_regs.sv
module pfo_offset_regs #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] preset_val_i,
    input  logic          ld_x_i,
    input  logic          ld_y_i,
    input  logic [AW-1:0] par_val_i,
    input  logic          shift_i,
    input  logic          ser_bit_i,
    output logic [AW-1:0] x_o,
    output logic [AW-1:0] y_o
);
    logic [AW-1:0] x_q, y_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= preset_val_i;
            y_q <= preset_val_i;
        end else if (shift_i) begin
            // The pair {Y,X} forms one shift chain entered at X's LSB.
            {y_q, x_q} <= {y_q[AW-2:0], x_q, ser_bit_i};
        end else begin
            if (ld_x_i) x_q <= par_val_i;
            if (ld_y_i) y_q <= par_val_i;
        end
    end

    assign x_o = x_q;
    assign y_o = y_q;

endmodule

// File: rtl/pfo_flag_cmp.sv
module pfo_flag_cmp #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    parameter int CW    = 11
) (
    input  logic [CW-1:0] count_i,
    input  logic [AW-1:0] x_i,
    input  logic [AW-1:0] y_i,
    output logic          ae_n_o,
    output logic          af_n_o
);
    logic [CW-1:0] ae_lim;
    logic [CW-1:0] af_lim;

    always_comb begin
        ae_lim = {1'b0, x_i};
        af_lim = CW'(DEPTH) - {1'b0, y_i};
        ae_n_o = !(count_i <= ae_lim);
        af_n_o = !(count_i >= af_lim);
    end

endmodule

// File: rtl/pfo_ctrl.sv
module pfo_ctrl
    import pfo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prst_n,
    input  logic       preset_sel_i,
    input  logic [1:0] fsel_i,
    input  logic       wr_en_i,
    input  logic       ser_en_n_i,
    input  logic       last_bit_i,
    output logic       ld_x_o,
    output logic       ld_y_o,
    output logic       shift_o,
    output logic       in_ready_o
);
    pfo_state_e state_q, state_nx;
    load_mode_e mode_q;

    // Mode pins are captured on every edge while the full reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= decode_mode(preset_sel_i, fsel_i);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RESET;
        else
            state_q <= state_nx;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RESET: begin
                unique case (mode_q)
                    LM_PRESET: state_nx = ST_RUN;
                    LM_SERIAL: state_nx = ST_SERIAL;
                    default:   state_nx = ST_PAR_X;
                endcase
            end
            ST_PAR_X:  if (wr_en_i) state_nx = ST_PAR_Y;
            ST_PAR_Y:  if (wr_en_i) state_nx = ST_RUN;
            ST_SERIAL: if (last_bit_i) state_nx = ST_RUN;
            ST_RUN:    state_nx = ST_RUN;
            default:   state_nx = ST_RESET;
        endcase
    end

    // Output decode.
    always_comb begin
        ld_x_o     = 1'b0;
        ld_y_o     = 1'b0;
        shift_o    = 1'b0;
        in_ready_o = 1'b0;
        unique case (state_q)
            ST_PAR_X:  ld_x_o = wr_en_i;
            ST_PAR_Y:  ld_y_o = wr_en_i;
            ST_SERIAL: shift_o = !ser_en_n_i;
            ST_RUN:    in_ready_o = prst_n;
            default:   ;
        endcase
    end

endmodule

// File: rtl/pflag_offset_unit.sv
module pflag_offset_unit
    import pfo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prst_n,
    input  logic          preset_sel_i,
    input  logic [1:0]    fsel_i,
    input  logic          ser_bit_i,
    input  logic          ser_en_n_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic [CW-1:0] word_cnt_i,
    output logic          almost_empty_n_o,
    output logic          almost_full_n_o,
    output logic [AW-1:0] x_off_o,
    output logic [AW-1:0] y_off_o,
    output logic          in_ready_o
);
    localparam int NBITS = 2 * AW;

    logic          ld_x, ld_y, shift_en, last_bit;
    logic [AW-1:0] preset_val;

    always_comb begin
        if (decode_mode(preset_sel_i, fsel_i) == LM_PRESET)
            preset_val = AW'(preset_offset(fsel_i));
        else
            preset_val = '0;
    end

    pfo_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .prst_n       (prst_n),
        .preset_sel_i (preset_sel_i),
        .fsel_i       (fsel_i),
        .wr_en_i      (wr_en_i),
        .ser_en_n_i   (ser_en_n_i),
        .last_bit_i   (last_bit),
        .ld_x_o       (ld_x),
        .ld_y_o       (ld_y),
        .shift_o      (shift_en),
        .in_ready_o   (in_ready_o)
    );

    pfo_bit_counter #(.NBITS(NBITS)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (shift_en),
        .last_o (last_bit)
    );

    pfo_offset_regs #(.AW(AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .preset_val_i (preset_val),
        .ld_x_i       (ld_x),
        .ld_y_i       (ld_y),
        .par_val_i    (wr_data_i),
        .shift_i      (shift_en),
        .ser_bit_i    (ser_bit_i),
        .x_o          (x_off_o),
        .y_o          (y_off_o)
    );

    pfo_flag_cmp #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_cmp (
        .count_i (word_cnt_i),
        .x_i     (x_off_o),
        .y_i     (y_off_o),
        .ae_n_o  (almost_empty_n_o),
        .af_n_o  (almost_full_n_o)
    );

endmodule

// File: rtl/pflag_offset_unit_chk.sv
module pflag_offset_unit_chk #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prst_n,
    input logic [CW-1:0] word_cnt_i,
    input logic          almost_empty_n_o,
    input logic          almost_full_n_o,
    input logic [AW-1:0] x_off_o,
    input logic [AW-1:0] y_off_o,
    input logic          in_ready_o
);
    // R9
    ready_needs_prst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> prst_n);

    // R6
    offsets_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |=> ($stable(x_off_o) && $stable(y_off_o)));

    // R7
    ae_only_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !almost_empty_n_o |-> (word_cnt_i <= {1'b0, x_off_o}));

    // R7
    ae_clear_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt_i == ({1'b0, x_off_o} + 1'b1)) |-> almost_empty_n_o);

    // R8
    af_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt_i == CW'(DEPTH)) |-> !almost_full_n_o);

    // R8
    af_clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cnt_i == '0) |-> almost_full_n_o);

endmodule

bind pflag_offset_unit pflag_offset_unit_chk #(.DEPTH(DEPTH)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .prst_n           (prst_n),
    .word_cnt_i       (word_cnt_i),
    .almost_empty_n_o (almost_empty_n_o),
    .almost_full_n_o  (almost_full_n_o),
    .x_off_o          (x_off_o),
    .y_off_o          (y_off_o),
    .in_ready_o       (in_ready_o)
);

// File: tb/pflag_offset_unit_tb_top.sv
module pflag_offset_unit_tb_top;
    localparam int DEPTH = 128;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = AW + 1;
    localparam int NB    = 2 * AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          preset_sel = 1'b0;
    logic [1:0]    fsel = 2'b00;
    logic          ser_bit = 1'b0;
    logic          ser_en_n = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_data = '0;
    logic [CW-1:0] word_cnt = '0;
    logic          ae_n, af_n, in_ready;
    logic [AW-1:0] x_off, y_off;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pflag_offset_unit #(.DEPTH(DEPTH)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .prst_n           (prst_n),
        .preset_sel_i     (preset_sel),
        .fsel_i           (fsel),
        .ser_bit_i        (ser_bit),
        .ser_en_n_i       (ser_en_n),
        .wr_en_i          (wr_en),
        .wr_data_i        (wr_data),
        .word_cnt_i       (word_cnt),
        .almost_empty_n_o (ae_n),
        .almost_full_n_o  (af_n),
        .x_off_o          (x_off),
        .y_off_o          (y_off),
        .in_ready_o       (in_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic ps, input logic [1:0] fs);
        @(negedge clk);
        rst_n = 1'b0;
        preset_sel = ps;
        fsel = fs;
        @(negedge clk);
        @(negedge clk);
        #1 chk("R4 ready low in reset", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic bus_write(input int v);
        @(negedge clk);
        wr_data = AW'(v);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic ser_send(input logic b, input logic en);
        @(negedge clk);
        ser_bit = b;
        ser_en_n = !en;
        @(negedge clk);
        ser_en_n = 1'b1;
        #1;
    endtask

    task automatic check_offsets(input string tag, input int ex, input int ey);
        chk({tag, " X"}, int'(x_off), ex);
        chk({tag, " Y"}, int'(y_off), ey);
    endtask

    // R7 R8: full count sweep against arithmetic thresholds
    task automatic sweep(input int ex, input int ey);
        for (int c = 0; c <= DEPTH; c++) begin
            word_cnt = CW'(c);
            #1;
            chk("R7 almost-empty", int'(ae_n), (c <= ex) ? 0 : 1);
            chk("R8 almost-full", int'(af_n), (c >= DEPTH - ey) ? 0 : 1);
        end
        word_cnt = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 presets
        do_reset(1'b1, 2'b01);
        chk("R1 ready after preset", in_ready, 1);
        check_offsets("R1 preset 8", 8, 8);
        sweep(8, 8);
        do_reset(1'b1, 2'b10);
        check_offsets("R1 preset 16", 16, 16);
        chk("R1 ready after preset", in_ready, 1);
        do_reset(1'b1, 2'b11);
        check_offsets("R1 preset 64", 64, 64);
        sweep(64, 64);

        // R3 parallel load, R4 hold-off
        do_reset(1'b0, 2'b00);
        chk("R4 ready low before parallel load", in_ready, 0);
        bus_write(5);
        chk("R3 X after first write", int'(x_off), 5);
        chk("R4 ready low after first write", in_ready, 0);
        bus_write(100);
        chk("R3 Y after second write", int'(y_off), 100);
        chk("R4 ready after second write", in_ready, 1);
        sweep(5, 100);
        // R6 bus write ignored after load
        bus_write(77);
        check_offsets("R6 write after load", 5, 100);

        // R9 partial reset
        @(negedge clk);
        prst_n = 1'b0;
        @(negedge clk);
        #1 chk("R9 ready low in partial reset", in_ready, 0);
        check_offsets("R9 offsets kept", 5, 100);
        prst_n = 1'b1;
        @(negedge clk);
        #1 chk("R9 ready back", in_ready, 1);
        check_offsets("R9 offsets kept after", 5, 100);

        // R2 R5 serial load: Y=37 then X=90, MSB first, with disabled gaps
        do_reset(1'b0, 2'b10);
        chk("R4 ready low before serial load", in_ready, 0);
        begin
            logic [NB-1:0] word;
            word = {AW'(37), AW'(90)};
            for (int i = NB - 1; i >= 0; i--) begin
                if (i % 3 == 0) ser_send(!word[i], 1'b0); // R5 disabled edge
                ser_send(word[i], 1'b1);
                if (i == 1) chk("R4 ready low before last bit", in_ready, 0);
            end
        end
        chk("R4 ready after last serial bit", in_ready, 1);
        check_offsets("R5 serial order", 90, 37);
        sweep(90, 37);
        // R6 bits after completion ignored
        for (int i = 0; i < 4; i++) ser_send(1'b1, 1'b1);
        check_offsets("R6 extra serial bits", 90, 37);

        // R10 new full reset reapplies configuration
        do_reset(1'b1, 2'b01);
        check_offsets("R10 reconfigured", 8, 8);

        // R3 boundary offsets via the other parallel pin combination
        do_reset(1'b1, 2'b00);
        chk("R3 parallel via preset_sel=1 fsel=00", in_ready, 0);
        bus_write(0);
        bus_write(0);
        check_offsets("R3 zero offsets", 0, 0);
        sweep(0, 0);
        do_reset(1'b0, 2'b01);
        bus_write(DEPTH - 1);
        bus_write(DEPTH - 1);
        check_offsets("R3 max offsets", DEPTH - 1, DEPTH - 1);
        sweep(DEPTH - 1, DEPTH - 1);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule